// File: doc/BRIEF.md
# Four-Way Streaming Partial-Sum Combiner

This block is one node of a summation tree. Four child links each stream the partial results for the same batch of target particles, one 32-bit word per transfer, with valid/ready flow control. Once a pass is started, a sequencer waits until all four children present a word. It then takes one word from each, adds the four with a single fixed-point integer adder, and sends the sum to the parent link. The word order is kept.

Each particle result is 64 bits wide and travels as two words, least significant word first. The low-word sum of four operands can carry up to two bits. That carry is held and added into the matching high-word sum, so the parent receives the full 64-bit total modulo 2^64. After the last word of the batch, the sequencer raises a one-cycle completion pulse and goes back to waiting. A batch is 48 particles, which is 96 words. The same node also copies downward broadcast traffic to its children, with one register stage and no change to the data.

Top module: `rtn_node`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid`, `done`, `bcastOutValid` and every bit of `inReady` are 0.
- R2: Outside a pass, no input word is accepted: `inReady` stays 0 even when all four `inValid` bits are 1. A pass begins on the clock edge that samples `start` high. It ends on the edge that accepts its last word.
- R3: Input words are taken only all together. `inReady` is either all zeros or all ones, and it is all ones only when all four `inValid` bits are 1.
- R4: Word k of a pass (k counted from 0) belongs to particle k/2. Even k carries bits 31:0 of the 64-bit sum of that particle's four operands, and odd k carries bits 63:32. The low-word carry, 0 to 3, enters only the high word of the same particle, never the next particle's low word.
- R5: While `outValid` is 1 and `outReady` is 0, `outData` holds its value and `outValid` stays 1.
- R6: A pass emits exactly 96 words. `done` is 1 for exactly one cycle, which is the cycle in which the 96th word first appears on `outData`.
- R7: Broadcast traffic moves down unchanged one cycle later. `bcastOutValid` and `bcastOutData` equal the `bcastInValid` and `bcastInData` of the previous cycle.
- R8: When all inputs are valid and the output is always ready, the node accepts one word per cycle. `done` rises no more than 98 cycles after the cycle in which `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a reduction pass when idle |
| inValid | input | 4 | Word valid, one bit per child link |
| inData | input | 128 | Child words, link i at bits 32*i+31:32*i |
| inReady | output | 4 | Word accepted, one bit per child link |
| outValid | output | 1 | Summed word valid toward the parent |
| outData | output | 32 | Summed word toward the parent |
| outReady | input | 1 | Parent accepts the summed word |
| done | output | 1 | One-cycle pulse when the last word of a pass is presented |
| bcastInValid | input | 1 | Broadcast word valid from the parent |
| bcastInData | input | 32 | Broadcast word from the parent |
| bcastOutValid | output | 1 | Broadcast word valid toward the children |
| bcastOutData | output | 32 | Broadcast word toward the children |

## Verification
The assertions assume that the parent does not drop `start` before it is sampled. They also assume that each child supplies exactly 96 words per pass, in particle order. The stimulus respects both. It pulses `start` only while the node is idle, and it drives each child from a per-link word index that never runs past the batch. Within those limits, valid gaps and parent stalls are random under a fixed seed, so one child is often held while the others wait. Directed passes use all-ones operands, which force a carry of 3, and saturated low words with random high words.

// File: rtl/rtn_pkg.sv
package rtn_pkg;
  // Strobes from the sequencer to the adder datapath
  typedef struct packed {
    logic fire;       // take one word from every child this cycle
    logic firstWord;  // word is the least significant of a result
  } rtn_strobe_t;
endpackage

// File: rtl/rtn_seq.sv
module rtn_seq
  import rtn_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int BATCH     = 48,
  parameter int WORDS_PER = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NUM_IN-1:0] inValid,
  input  logic              outFree,
  output rtn_strobe_t       strobe,
  output logic              done
);
  localparam int WORD_TOTAL = BATCH * WORDS_PER;
  localparam int CNT_W      = $clog2(WORD_TOTAL + 1);
  localparam int PH_W       = (WORDS_PER > 1) ? $clog2(WORDS_PER) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_TOTAL - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(WORDS_PER - 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state;
  logic [CNT_W-1:0] wordCnt;
  logic [PH_W-1:0]  phase;
  logic             lastWord;

  always_comb begin
    strobe.fire      = (state == S_RUN) && (&inValid) && outFree;
    strobe.firstWord = (phase == '0);
    lastWord         = (wordCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordCnt <= '0;
      phase   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            wordCnt <= '0;
            phase   <= '0;
          end
        end
        S_RUN: begin
          if (strobe.fire) begin
            wordCnt <= wordCnt + 1'b1;
            phase   <= (phase == LAST_PH) ? '0 : phase + 1'b1;
            if (lastWord) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtn_sum.sv
module rtn_sum
  import rtn_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rtn_strobe_t              strobe,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  input  logic                     outReady,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic                     outFree
);
  localparam int CW    = $clog2(NUM_IN);
  localparam int SUM_W = DATA_W + CW;

  logic [CW-1:0]    carryReg;
  logic [CW-1:0]    carryIn;
  logic [SUM_W-1:0] acc;

  always_comb begin
    carryIn = strobe.firstWord ? '0 : carryReg;
    acc     = {{DATA_W{1'b0}}, carryIn};
    for (int i = 0; i < NUM_IN; i++) begin
      acc = acc + {{CW{1'b0}}, inData[i*DATA_W +: DATA_W]};
    end
    outFree = !outValid || outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      carryReg <= '0;
    end else if (strobe.fire) begin
      outValid <= 1'b1;
      outData  <= acc[DATA_W-1:0];
      carryReg <= acc[SUM_W-1:DATA_W];
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtn_bcast.sv
module rtn_bcast #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              dstValid,
  output logic [DATA_W-1:0] dstData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstValid <= 1'b0;
      dstData  <= '0;
    end else begin
      dstValid <= srcValid;
      dstData  <= srcData;
    end
  end
endmodule

// File: rtl/rtn_node.sv
module rtn_node
  import rtn_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_IN    = 4,
  parameter int BATCH     = 48,
  parameter int WORDS_PER = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  output logic [NUM_IN-1:0]        inReady,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  input  logic                     outReady,
  output logic                     done,
  input  logic                     bcastInValid,
  input  logic [DATA_W-1:0]        bcastInData,
  output logic                     bcastOutValid,
  output logic [DATA_W-1:0]        bcastOutData
);
  rtn_strobe_t strobe;
  logic        outFree;

  rtn_seq #(.NUM_IN(NUM_IN), .BATCH(BATCH), .WORDS_PER(WORDS_PER)) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .outFree(outFree), .strobe(strobe), .done(done)
  );

  rtn_sum #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_sum (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outFree(outFree)
  );

  rtn_bcast #(.DATA_W(DATA_W)) u_bcast (
    .clk(clk), .rstN(rstN), .srcValid(bcastInValid), .srcData(bcastInData),
    .dstValid(bcastOutValid), .dstData(bcastOutData)
  );

  assign inReady = {NUM_IN{strobe.fire}};
endmodule

// File: rtl/rtn_node_chk.sv
module rtn_node_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_IN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] inValid,
  input logic [NUM_IN-1:0] inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady,
  input logic              done,
  input logic              bcastInValid,
  input logic [DATA_W-1:0] bcastInData,
  input logic              bcastOutValid,
  input logic [DATA_W-1:0] bcastOutData
);
  AST_JOIN_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (inReady != '0) |-> (&inReady)); // R3
  AST_JOIN_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (|inReady) |-> (&inValid)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid); // R6
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rstN)
    bcastInValid |=> (bcastOutValid && bcastOutData == $past(bcastInData))); // R7
endmodule

bind rtn_node rtn_node_chk #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady), .done(done),
  .bcastInValid(bcastInValid), .bcastInData(bcastInData),
  .bcastOutValid(bcastOutValid), .bcastOutData(bcastOutData)
);

// File: tb/sim_rtn_node.sv
`timescale 1ns/1ps
module sim_rtn_node;
  localparam int NIN   = 4;
  localparam int NPART = 48;
  localparam int TOTAL = NPART * 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [NIN-1:0]   inValid = '0;
  logic [NIN*32-1:0] inData = '0;
  logic [NIN-1:0]   inReady;
  logic             outValid;
  logic [31:0]      outData;
  logic             outReady = 1'b0;
  logic             done;
  logic             bcastInValid = 1'b0;
  logic [31:0]      bcastInData = '0;
  logic             bcastOutValid;
  logic [31:0]      bcastOutData;

  always #2.5 clk = ~clk;

  rtn_node u0 (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outReady(outReady),
    .done(done), .bcastInValid(bcastInValid), .bcastInData(bcastInData),
    .bcastOutValid(bcastOutValid), .bcastOutData(bcastOutData)
  );

  int nRun = 0;
  int nFail = 0;
  logic [63:0] vals [NIN][NPART];
  logic        prevBV;
  logic [31:0] prevBD;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(int k);
    logic [63:0] s = '0;
    for (int i = 0; i < NIN; i++) s = s + vals[i][k/2];
    return (k % 2 == 1) ? s[63:32] : s[31:0];
  endfunction

  function automatic logic [31:0] childWord(int i, int k);
    return (k % 2 == 1) ? vals[i][k/2][63:32] : vals[i][k/2][31:0];
  endfunction

  // mode 0: all ones, 1: random, 2: saturated low words, 3: full throughput random
  task automatic fill(int mode);
    for (int i = 0; i < NIN; i++)
      for (int p = 0; p < NPART; p++) begin
        case (mode)
          0: vals[i][p] = '1;
          2: vals[i][p] = {$urandom(), 32'hFFFF_FFFF};
          default: vals[i][p] = {$urandom(), $urandom()};
        endcase
      end
  endtask

  task automatic bcastStep();
    // R7: output shows previous cycle's broadcast input
    check(bcastOutValid == prevBV && (!prevBV || bcastOutData == prevBD), "R7 bcast",
          {31'b0, bcastOutValid, bcastOutData}, {31'b0, prevBV, prevBD});
    prevBV = bcastInValid;
    prevBD = bcastInData;
  endtask

  task automatic idleCheck(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      inValid = '1;
      outReady = 1'b1;
      bcastInValid = $urandom_range(0, 1);
      bcastInData = $urandom();
      #2;
      check(inReady == '0, "R2 idle accepts nothing", inReady, 0);
      check(!done, "R6 no extra done", done, 0);
      bcastStep();
    end
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic runBatch(int mode);
    int idx [NIN];
    logic [NIN-1:0] vld;
    int outIdx = 0;
    int cyc = 0;
    int doneCnt = 0;
    bit held = 0;
    logic [31:0] heldData = '0;
    fill(mode);
    vld = '0;
    for (int i = 0; i < NIN; i++) idx[i] = 0;
    while (!(doneCnt > 0 && outIdx == TOTAL)) begin
      @(negedge clk);
      start = (cyc == 0);
      for (int i = 0; i < NIN; i++) begin
        if (!vld[i] && idx[i] < TOTAL)
          vld[i] = (mode == 3) ? 1'b1 : ($urandom_range(0, 3) != 0);
        inData[i*32 +: 32] = (idx[i] < TOTAL) ? childWord(i, idx[i]) : 32'h0;
      end
      inValid = vld;
      outReady = (mode == 3) ? 1'b1 : ($urandom_range(0, 3) != 0);
      bcastInValid = $urandom_range(0, 1);
      bcastInData = $urandom();
      #2;
      if (held)
        check(outValid && outData == heldData, "R5 held word", outData, heldData);
      if (|inReady)
        check((&inReady) && (&vld), "R3 join", {inReady, vld}, {NIN{1'b1}});
      for (int i = 0; i < NIN; i++)
        if (inReady[i] && vld[i]) begin
          idx[i]++;
          vld[i] = 1'b0;
        end
      if (done) begin
        doneCnt++;
        check(doneCnt == 1 && outIdx == TOTAL - 1, "R6 done timing", outIdx, TOTAL - 1);
        if (mode == 3) check(cyc <= TOTAL + 2, "R8 throughput", cyc, TOTAL + 2);
      end
      held = outValid && !outReady;
      heldData = outData;
      if (outValid && outReady) begin
        check(outIdx < TOTAL && outData == expWord(outIdx), "R4 word sum", outData, expWord(outIdx));
        outIdx++;
      end
      bcastStep();
      cyc++;
      if (cyc > 20000) begin
        check(0, "R6 watchdog", cyc, 0);
        break;
      end
    end
    @(negedge clk);
    start = 1'b0;
    inValid = '0;
    check(outIdx == TOTAL, "R6 word count", outIdx, TOTAL);
  endtask

  initial begin
    #400000;
    check(0, "R6 global watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    prevBV = 1'b0;
    prevBD = '0;
    repeat (3) @(negedge clk);
    #2;
    check(!outValid && !done && !bcastOutValid && inReady == '0, "R1 reset outputs",
          {outValid, done, bcastOutValid, inReady}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(!outValid && !done && !bcastOutValid && inReady == '0, "R1 after reset",
          {outValid, done, bcastOutValid, inReady}, 0);
    idleCheck(4);
    runBatch(0);  // R4: carry of 3 into every high word
    idleCheck(3);
    runBatch(2);  // R4: saturated low words
    runBatch(1);
    idleCheck(2);
    runBatch(3);  // R8
    runBatch(1);
    idleCheck(3);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule